// File: doc/BRIEF.md
# Accumulator and Link-Bit ALU

This block holds a 16-bit accumulator and a 1-bit link (carry) register that sits above the accumulator's most significant bit. Each cycle a sequencer may raise one bit of a one-hot operation select. The block then applies that operation to the accumulator and, for some operations, to the link bit. The operations are: bitwise AND with the data operand, addition of the data operand with the carry kept in the link bit, transfer of the data operand, low-byte input transfer, clear, complement, a 17-bit rotate in either direction, and increment.

The data operand and the input byte come in as plain inputs. The accumulator and link values go out directly. Three status flags are derived from them: accumulator sign, accumulator zero and link zero. Skip logic elsewhere in the processor tests these flags. Bus arbitration and instruction decoding stay outside the block. All results are registered on the rising clock edge, so each operation is visible on the outputs one cycle after its select is sampled.

Top module: `acc_link_alu`

## Requirements
- R1: After reset (rst_n low), the accumulator and the link bit are both 0.
- R2: When op_sel bit 0 is set, the accumulator takes accumulator AND dr_in on the next edge, and the link bit is unchanged.
- R3: When op_sel bit 1 is set, the 17-bit value {link, acc} takes the unsigned sum acc + dr_in, so the carry out lands in the link bit (0x0031 + 0x0025 gives 0x0056 with link 0).
- R4: When op_sel bit 2 is set, the accumulator takes dr_in unchanged, and the link bit is unchanged.
- R5: When op_sel bit 3 is set, acc[7:0] takes inp_in, while acc[15:8] and the link bit are unchanged.
- R6: When op_sel bit 4 is set, the accumulator is cleared. When op_sel bit 6 is set, the accumulator is bitwise inverted. In both cases the link bit is unchanged.
- R7: When op_sel bit 5 is set, the link bit is cleared. When op_sel bit 7 is set, the link bit is inverted. In both cases the accumulator is unchanged.
- R8: When op_sel bit 8 is set, {link, acc} rotates right by one position (acc[0] goes to link, and link goes to acc[15]). When op_sel bit 9 is set, it rotates left by one position (link goes to acc[0], and acc[15] goes to link).
- R9: When op_sel bit 10 is set, {link, acc} takes acc + 1, so the link bit becomes the carry out and its old value is lost.
- R10: At most one op_sel bit is set in a cycle. When none is set, the accumulator and the link bit hold their values.
- R11: acc_neg equals acc[15], acc_zero is 1 exactly when the accumulator is 0, and link_zero is 1 exactly when the link bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 11 | One-hot operation select (bit positions as in R2 to R9) |
| dr_in | input | 16 | Data operand |
| inp_in | input | 8 | Input byte |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link (carry) bit |
| acc_neg | output | 1 | Accumulator sign bit |
| acc_zero | output | 1 | Accumulator equals zero |
| link_zero | output | 1 | Link bit equals zero |

## Verification
The bench goes after the carry boundaries: addition and increment that overflow out of 0xFFFF to exactly zero. A design that drops the 17th bit would leave the link bit at 0 there and raise the wrong zero flag. It also checks increment with the link bit already set, which catches a design that ORs in the carry instead of replacing it. The rotates are swept with both link values against single-bit accumulator patterns at each end, so a 16-bit rotate that skips the link bit shows up at once. The input transfer is run over a non-zero upper byte, and every operation that should leave the link bit alone is run with it set, so a design that masks the wrong half or loads the link bit on every operation is reported.

// File: rtl/acc_link_alu.sv
module acc_link_alu #(
  parameter int W  = 16,
  parameter int IW = 8,
  parameter int NOPS = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOPS-1:0] op_sel,
  input  logic [W-1:0]    dr_in,
  input  logic [IW-1:0]   inp_in,
  output logic [W-1:0]    acc,
  output logic            link,
  output logic            acc_neg,
  output logic            acc_zero,
  output logic            link_zero
);
  localparam int OP_AND = 0;
  localparam int OP_ADD = 1;
  localparam int OP_LDR = 2;
  localparam int OP_INP = 3;
  localparam int OP_CLR = 4;
  localparam int OP_CLL = 5;
  localparam int OP_CMP = 6;
  localparam int OP_CML = 7;
  localparam int OP_ROR = 8;
  localparam int OP_ROL = 9;
  localparam int OP_INC = 10;

  logic [W:0]   sum_dr, sum_one;
  logic [W-1:0] acc_d;
  logic         link_d;

  assign sum_dr  = {1'b0, acc} + {1'b0, dr_in};
  assign sum_one = {1'b0, acc} + {{W{1'b0}}, 1'b1};

  always_comb begin
    acc_d  = acc;
    link_d = link;
    if (op_sel[OP_AND]) acc_d = acc & dr_in;
    if (op_sel[OP_ADD]) {link_d, acc_d} = sum_dr;
    if (op_sel[OP_LDR]) acc_d = dr_in;
    if (op_sel[OP_INP]) acc_d[IW-1:0] = inp_in;
    if (op_sel[OP_CLR]) acc_d = '0;
    if (op_sel[OP_CLL]) link_d = 1'b0;
    if (op_sel[OP_CMP]) acc_d = ~acc;
    if (op_sel[OP_CML]) link_d = ~link;
    if (op_sel[OP_ROR]) {link_d, acc_d} = {acc[0], link, acc[W-1:1]};
    if (op_sel[OP_ROL]) {link_d, acc_d} = {acc, link};
    if (op_sel[OP_INC]) {link_d, acc_d} = sum_one;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      link <= 1'b0;
    end else begin
      acc  <= acc_d;
      link <= link_d;
    end
  end

  assign acc_neg   = acc[W-1];
  assign acc_zero  = (acc == '0);
  assign link_zero = ~link;
endmodule

// File: rtl/acc_link_alu_chk.sv
module acc_link_alu_chk #(
  parameter int W  = 16,
  parameter int IW = 8,
  parameter int NOPS = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NOPS-1:0] op_sel,
  input logic [W-1:0]    dr_in,
  input logic [IW-1:0]   inp_in,
  input logic [W-1:0]    acc,
  input logic            link,
  input logic            acc_zero,
  input logic            link_zero
);
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(op_sel));

  a_r2_and: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[0] |=> (acc == ($past(acc) & $past(dr_in))) && (link == $past(link)));

  a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[1] |=> ({link, acc} == ({1'b0, $past(acc)} + {1'b0, $past(dr_in)})));

  a_r5_inp: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[3] |=> (acc[IW-1:0] == $past(inp_in)) && (acc[W-1:IW] == $past(acc[W-1:IW])));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[4] |=> acc_zero);

  a_r7_clear_link: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[5] |=> link_zero && $stable(acc));

  a_r8_ror: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[8] |=> ({link, acc} == {$past(acc[0]), $past(link), $past(acc[W-1:1])}));

  a_r8_rol: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[9] |=> ({link, acc} == {$past(acc), $past(link)}));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == '0) |=> $stable(acc) && $stable(link));
endmodule

bind acc_link_alu acc_link_alu_chk #(.W(W), .IW(IW), .NOPS(NOPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .dr_in(dr_in), .inp_in(inp_in),
  .acc(acc), .link(link), .acc_zero(acc_zero), .link_zero(link_zero)
);

// File: tb/acc_link_alu_test.sv
`timescale 1ns/1ps
module acc_link_alu_test;
  localparam int W = 16;
  localparam int IW = 8;
  localparam int NOPS = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NOPS-1:0] op_sel = '0;
  logic [W-1:0] dr_in = '0;
  logic [IW-1:0] inp_in = '0;
  logic [W-1:0] acc;
  logic link, acc_neg, acc_zero, link_zero;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] m_acc = '0;
  logic m_link = 1'b0;

  always #2 clk = ~clk;

  acc_link_alu #(.W(W), .IW(IW), .NOPS(NOPS)) uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .dr_in(dr_in), .inp_in(inp_in),
    .acc(acc), .link(link), .acc_neg(acc_neg), .acc_zero(acc_zero), .link_zero(link_zero)
  );

  task automatic compare(input string tag);
    checks++;
    if (acc !== m_acc || link !== m_link || acc_neg !== m_acc[W-1] ||
        acc_zero !== (m_acc == 0) || link_zero !== !m_link) begin
      failures++;
      $display("FAIL %s: acc=%h link=%b neg=%b z=%b lz=%b expected acc=%h link=%b",
               tag, acc, link, acc_neg, acc_zero, link_zero, m_acc, m_link);
    end
  endtask

  task automatic run(input int op, input logic [W-1:0] d, input logic [IW-1:0] b, input string tag);
    logic [W:0] t;
    @(negedge clk);
    op_sel = '0;
    if (op >= 0) op_sel[op] = 1'b1;
    dr_in = d;
    inp_in = b;
    case (op)
      0: m_acc = m_acc & d;
      1: begin t = {1'b0, m_acc} + {1'b0, d}; {m_link, m_acc} = t; end
      2: m_acc = d;
      3: m_acc = {m_acc[W-1:IW], b};
      4: m_acc = 0;
      5: m_link = 1'b0;
      6: m_acc = ~m_acc;
      7: m_link = ~m_link;
      8: {m_link, m_acc} = {m_acc[0], m_link, m_acc[W-1:1]};
      9: {m_link, m_acc} = {m_acc, m_link};
      10: begin t = {1'b0, m_acc} + 17'd1; {m_link, m_acc} = t; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    op_sel = '0;
    compare(tag);
  endtask

  task automatic set_state(input logic [W-1:0] a, input logic e);
    run(2, a, 8'h00, "R4 load");
    if (m_link != e) run(7, 16'h0, 8'h00, "R7 invert link");
  endtask

  initial begin
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    set_state(16'h0031, 1'b1);
    run(0, 16'h0025, 8'h00, "R2 and example");
    checks++;
    if (acc !== 16'h0021) begin failures++; $display("FAIL R2: acc=%h expected 0021", acc); end
    set_state(16'h0031, 1'b1);
    run(1, 16'h0025, 8'h00, "R3 add example");
    checks++;
    if (acc !== 16'h0056 || link !== 1'b0) begin
      failures++; $display("FAIL R3: acc=%h link=%b expected 0056 0", acc, link);
    end

    set_state(16'hFFFF, 1'b0);
    run(1, 16'h0001, 8'h00, "R3 add wrap to zero");
    set_state(16'hFFFF, 1'b0);
    run(10, 16'h0, 8'h00, "R9 inc wrap");
    set_state(16'h1234, 1'b1);
    run(10, 16'h0, 8'h00, "R9 inc replaces link");
    set_state(16'h0001, 1'b1);
    run(8, 16'h0, 8'h00, "R8 ror");
    run(8, 16'h0, 8'h00, "R8 ror");
    set_state(16'h8000, 1'b0);
    run(9, 16'h0, 8'h00, "R8 rol");
    run(9, 16'h0, 8'h00, "R8 rol");
    set_state(16'hAB00, 1'b1);
    run(3, 16'h0, 8'h5C, "R5 inp keeps upper");
    run(4, 16'h0, 8'h00, "R6 clear acc");
    run(6, 16'h0, 8'h00, "R6 invert acc");
    run(5, 16'h0, 8'h00, "R7 clear link");
    run(7, 16'h0, 8'h00, "R7 invert link");
    for (int k = 0; k < 4; k++) run(-1, 16'hFFFF, 8'hFF, "R10 hold");

    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a, d;
      a = W'((i * 40503 + 7) & 16'hFFFF);
      d = W'((i * 9973 + 12345) & 16'hFFFF);
      set_state(a, i[0]);
      case (i % 11)
        0: run(0, d, 8'h00, "R2 and sweep");
        1: run(1, d, 8'h00, "R3 add sweep");
        2: run(2, d, 8'h00, "R4 load sweep");
        3: run(3, d, d[7:0], "R5 inp sweep");
        4: run(4, d, 8'h00, "R6 clear sweep");
        5: run(5, d, 8'h00, "R7 clear link sweep");
        6: run(6, d, 8'h00, "R6 invert sweep");
        7: run(7, d, 8'h00, "R7 invert link sweep");
        8: run(8, d, 8'h00, "R8 ror sweep");
        9: run(9, d, 8'h00, "R8 rol sweep");
        default: run(10, d, 8'h00, "R9 inc sweep");
      endcase
      run(-1, d, d[15:8], "R10 R11 hold sweep");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule